// File: doc/BRIEF.md
# External Data Memory Mode Router

This block decides, for every access an 8-bit microcontroller makes to its external data space, whether the access lands in the 4 KB on-chip RAM or goes out on the off-chip address bus. Each access has four inputs that shape it: a 2-bit mode field, an access-width flag, a read/write flag and an access strobe. The width flag chooses between an 8-bit indirect access and a 16-bit pointer access. An 8-bit indirect access builds its address from a page register (high byte) and a low-address register (low byte). A 16-bit access uses a 16-bit data pointer directly.

For an on-chip target the block presents a 12-bit RAM address. For an off-chip target it presents the 16-bit bus address and two drive enables, one for the upper address byte and one for the lower. When the upper enable is low, port logic outside the block keeps control of the upper address pins. Every decision is captured on the access strobe, and the result appears on registered outputs one clock later. The RAM, the bus timing and multiplexing, and the port pins are outside the block.

Top module: `xd_router`

## Requirements
- R1: The mode field encodes 00 = on-chip only, 01 = split with the upper byte left to the ports, 10 = split with the upper byte taken from the page register, and 11 = off-chip only. In mode 00 every access selects on-chip RAM, whatever the address, so 0x1000 and 0x2000 both reach on-chip address 0x000.
- R2: When the width flag is 0 (8-bit access), the effective address is {page, low}, and for an off-chip access bus_addr_o equals that value.
- R3: When the width flag is 1 (16-bit access), the effective address is the 16-bit data pointer.
- R4: In modes 01 and 10, an effective address below 0x1000 selects on-chip RAM, and an address of 0x1000 or above selects off-chip.
- R5: In mode 01, an 8-bit off-chip access asserts only the lower-byte drive enable. The upper-byte enable stays low.
- R6: A 16-bit off-chip access asserts both drive enables in every mode that reaches off-chip, and bus_addr_o equals the pointer.
- R7: In mode 10, an 8-bit off-chip access asserts both drive enables, and the upper bus byte is the page register.
- R8: In mode 11, every access selects off-chip with both drive enables asserted. This includes addresses below 0x1000.
- R9: On every access, whether on-chip or off-chip, onchip_addr_o is the low 12 bits of the effective address.
- R10: The outputs of an access are valid exactly one clock after the cycle in which the strobe is sampled high, and wr_o carries that access's write flag. After a cycle with no strobe, both select outputs and both drive enables are low.
- R11: The mode is sampled together with each access. A mode change affects only accesses that are strobed later.
- R12: After reset, every output is zero until the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Memory mode field |
| wide_i | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit indirect access |
| page_i | input | 8 | Page register (high byte of an 8-bit access) |
| low_i | input | 8 | Low-address register (low byte of an 8-bit access) |
| ptr_i | input | 16 | 16-bit data pointer |
| wr_i | input | 1 | 1 = write, 0 = read |
| strobe_i | input | 1 | Access request, one cycle per access |
| onchip_sel_o | output | 1 | Access targets on-chip RAM |
| offchip_sel_o | output | 1 | Access targets the off-chip bus |
| onchip_addr_o | output | 12 | On-chip RAM address |
| bus_addr_o | output | 16 | Off-chip bus address |
| drive_hi_o | output | 1 | Drive enable for bus address bits 15:8 |
| drive_lo_o | output | 1 | Drive enable for bus address bits 7:0 |
| wr_o | output | 1 | Write flag of the registered access |

## Verification
The bench probes addresses on both sides of the 0x1000 boundary: 0x0FFF, 0x1000 and 0xFFFF.

- **Boundary compare.** It probes these addresses in both split modes and at both widths. A design with an off-by-one compare, or one that tests only some of the upper bits, routes one of them the wrong way.
- **Upper-byte enable.** It sends 8-bit off-chip accesses in modes 01, 10 and 11. A design that ties the upper-byte enable to the mode alone, or to the width alone, misdrives it in at least one of these cases.
- **Wrap in mode 00.** It checks that high addresses in mode 00 wrap onto on-chip RAM.
- **Low addresses in mode 11.** It checks that low addresses in mode 11 still go off-chip.
- **Back-to-back accesses.** It issues accesses on consecutive cycles with a different mode each time. A design that samples the mode late, or adds a pipeline stage, shows the wrong routing or a one-cycle skew.

// File: rtl/xd_pkg.sv
package xd_pkg;

  typedef enum logic [1:0] {
    XM_LOCAL    = 2'b00,
    XM_SPLIT_NB = 2'b01,
    XM_SPLIT_BK = 2'b10,
    XM_REMOTE   = 2'b11
  } xmode_e;

  typedef struct packed {
    logic on_sel;
    logic off_sel;
    logic drv_hi;
    logic drv_lo;
  } route_t;

endpackage

// File: rtl/xd_ea_mux.sv
module xd_ea_mux #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] page_i,
  input  logic [BYTE_W-1:0] low_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] ea_o
);

  // 16-bit accesses use the pointer; 8-bit accesses join page and low bytes
  always_comb begin
    if (wide_i) ea_o = ptr_i;
    else        ea_o = {page_i, low_i};
  end

endmodule

// File: rtl/xd_route.sv
module xd_route
  import xd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LOCAL_AW = 12
) (
  input  xmode_e            mode_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] ea_i,
  output route_t            route_o
);

  localparam int HI_W = ADDR_W - LOCAL_AW;

  logic above;
  assign above = (ea_i[ADDR_W-1 -: HI_W] != '0);

  always_comb begin
    route_o = '0;
    unique case (mode_i)
      XM_LOCAL: route_o.on_sel = 1'b1;
      XM_SPLIT_NB: begin
        if (above) begin
          route_o.off_sel = 1'b1;
          route_o.drv_lo  = 1'b1;
          route_o.drv_hi  = wide_i;
        end else begin
          route_o.on_sel = 1'b1;
        end
      end
      XM_SPLIT_BK: begin
        if (above) begin
          route_o.off_sel = 1'b1;
          route_o.drv_lo  = 1'b1;
          route_o.drv_hi  = 1'b1;
        end else begin
          route_o.on_sel = 1'b1;
        end
      end
      XM_REMOTE: begin
        route_o.off_sel = 1'b1;
        route_o.drv_lo  = 1'b1;
        route_o.drv_hi  = 1'b1;
      end
      default: route_o = '0;
    endcase
  end

endmodule

// File: rtl/xd_router.sv
module xd_router
  import xd_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LOCAL_AW = 12,
  localparam int ADDR_W  = 2 * BYTE_W,
  localparam int PG_LO   = LOCAL_AW - BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_i,
  input  logic                wide_i,
  input  logic [BYTE_W-1:0]   page_i,
  input  logic [BYTE_W-1:0]   low_i,
  input  logic [ADDR_W-1:0]   ptr_i,
  input  logic                wr_i,
  input  logic                strobe_i,
  output logic                onchip_sel_o,
  output logic                offchip_sel_o,
  output logic [LOCAL_AW-1:0] onchip_addr_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic                drive_hi_o,
  output logic                drive_lo_o,
  output logic                wr_o
);

  logic [ADDR_W-1:0] ea;
  route_t            route_d;
  route_t            route_q;

  xd_ea_mux #(.BYTE_W(BYTE_W)) u_ea (
    .wide_i (wide_i),
    .page_i (page_i),
    .low_i  (low_i),
    .ptr_i  (ptr_i),
    .ea_o   (ea)
  );

  xd_route #(.ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW)) u_route (
    .mode_i  (xmode_e'(mode_i)),
    .wide_i  (wide_i),
    .ea_i    (ea),
    .route_o (route_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q       <= '0;
      onchip_addr_o <= '0;
      bus_addr_o    <= '0;
      wr_o          <= 1'b0;
    end else begin
      route_q <= strobe_i ? route_d : '0;
      if (strobe_i) begin
        onchip_addr_o <= ea[LOCAL_AW-1:0];
        bus_addr_o    <= ea;
        wr_o          <= wr_i;
      end
    end
  end

  assign onchip_sel_o  = route_q.on_sel;
  assign offchip_sel_o = route_q.off_sel;
  assign drive_hi_o    = route_q.drv_hi;
  assign drive_lo_o    = route_q.drv_lo;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> !onchip_sel_o && !offchip_sel_o && !drive_hi_o && !drive_lo_o); // R10
  AST_LOCAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    strobe_i && mode_i == 2'b00 |=> onchip_sel_o && !offchip_sel_o && !drive_hi_o); // R1
  AST_REMOTE_ALL: assert property (@(posedge clk) disable iff (rst)
    strobe_i && mode_i == 2'b11 |=> offchip_sel_o && drive_hi_o && drive_lo_o); // R8
  AST_NB_NARROW_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    strobe_i && mode_i == 2'b01 && !wide_i && page_i[BYTE_W-1:PG_LO] != '0
    |=> offchip_sel_o && drive_lo_o && !drive_hi_o); // R5
  AST_WIDE_FULL_DRIVE: assert property (@(posedge clk) disable iff (rst)
    strobe_i && wide_i && mode_i != 2'b00 && ptr_i[ADDR_W-1:LOCAL_AW] != '0
    |=> offchip_sel_o && drive_hi_o && drive_lo_o); // R6
  AST_SPLIT_LOW_LOCAL: assert property (@(posedge clk) disable iff (rst)
    strobe_i && wide_i && (mode_i == 2'b01 || mode_i == 2'b10) && ptr_i[ADDR_W-1:LOCAL_AW] == '0
    |=> onchip_sel_o && !offchip_sel_o); // R4
  AST_WIDE_LOCAL_ADDR: assert property (@(posedge clk) disable iff (rst)
    strobe_i && wide_i |=> onchip_addr_o == $past(ptr_i[LOCAL_AW-1:0])); // R9
  AST_NARROW_BUS_ADDR: assert property (@(posedge clk) disable iff (rst)
    strobe_i && !wide_i |=> bus_addr_o == $past({page_i, low_i})); // R2
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(onchip_sel_o && offchip_sel_o)); // R4

endmodule

// File: tb/tb_xd_router.sv
module tb_xd_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = '0;
  logic        wide_i = 1'b0;
  logic [7:0]  page_i = '0;
  logic [7:0]  low_i = '0;
  logic [15:0] ptr_i = '0;
  logic        wr_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic        onchip_sel_o, offchip_sel_o, drive_hi_o, drive_lo_o, wr_o;
  logic [11:0] onchip_addr_o;
  logic [15:0] bus_addr_o;

  always #2.5 clk = ~clk;

  xd_router dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .wide_i(wide_i), .page_i(page_i),
    .low_i(low_i), .ptr_i(ptr_i), .wr_i(wr_i), .strobe_i(strobe_i),
    .onchip_sel_o(onchip_sel_o), .offchip_sel_o(offchip_sel_o),
    .onchip_addr_o(onchip_addr_o), .bus_addr_o(bus_addr_o),
    .drive_hi_o(drive_hi_o), .drive_lo_o(drive_lo_o), .wr_o(wr_o)
  );

  typedef struct {
    logic        on_sel;
    logic        off_sel;
    logic        hi;
    logic        lo;
    logic [11:0] oaddr;
    logic [15:0] baddr;
    logic        wr;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  logic  mon_en   = 1'b0;

  function automatic item_t model(input logic [1:0] m, input logic w, input logic [7:0] pg,
                                  input logic [7:0] lo, input logic [15:0] p,
                                  input logic wr, input string tag);
    item_t       it;
    logic [15:0] ea;
    logic        above;
    ea    = w ? p : {pg, lo};
    above = ea >= 16'h1000;
    it.on_sel = 0; it.off_sel = 0; it.hi = 0; it.lo = 0;
    it.oaddr = ea[11:0]; it.baddr = ea; it.wr = wr; it.tag = tag;
    case (m)
      2'b00: it.on_sel = 1;
      2'b01: if (above) begin it.off_sel = 1; it.lo = 1; it.hi = w; end else it.on_sel = 1;
      2'b10: if (above) begin it.off_sel = 1; it.lo = 1; it.hi = 1; end else it.on_sel = 1;
      default: begin it.off_sel = 1; it.lo = 1; it.hi = 1; end
    endcase
    return it;
  endfunction

  task automatic acc(input logic [1:0] m, input logic w, input logic [7:0] pg,
                     input logic [7:0] lo, input logic [15:0] p, input logic wr,
                     input string tag);
    mode_i = m; wide_i = w; page_i = pg; low_i = lo; ptr_i = p; wr_i = wr;
    strobe_i = 1'b1;
    exp_q.push_back(model(m, w, pg, lo, p, wr, tag));
    @(negedge clk);
    strobe_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per strobed cycle, checks idle otherwise
  initial begin
    logic  armed;
    item_t it;
    wait (mon_en);
    forever begin
      @(posedge clk);
      armed = strobe_i;
      @(negedge clk);
      if (armed) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R10 scoreboard empty actual=1 expected=0");
        end else begin
          it = exp_q.pop_front();
          chk({it.tag, " on_sel"},  64'(onchip_sel_o),  64'(it.on_sel));
          chk({it.tag, " off_sel"}, 64'(offchip_sel_o), 64'(it.off_sel));
          chk({it.tag, " drv_hi"},  64'(drive_hi_o),    64'(it.hi));
          chk({it.tag, " drv_lo"},  64'(drive_lo_o),    64'(it.lo));
          chk({it.tag, " onchip_addr (R9)"}, 64'(onchip_addr_o), 64'(it.oaddr));
          if (it.off_sel) chk({it.tag, " bus_addr"}, 64'(bus_addr_o), 64'(it.baddr));
          chk({it.tag, " wr (R10)"}, 64'(wr_o), 64'(it.wr));
        end
      end else begin
        chk("R10 idle outputs low",
            64'({onchip_sel_o, offchip_sel_o, drive_hi_o, drive_lo_o}), 64'(0));
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset outputs zero",
        64'({onchip_sel_o, offchip_sel_o, drive_hi_o, drive_lo_o, wr_o, onchip_addr_o, bus_addr_o}),
        64'(0));
    mon_en = 1'b1;
    idle(1);

    // R1: mode 00, wrap on 4 KB
    acc(2'b00, 1, 8'h00, 8'h00, 16'h1000, 0, "R1 local wrap 0x1000");
    acc(2'b00, 1, 8'h00, 8'h00, 16'h2000, 1, "R1 local wrap 0x2000");
    acc(2'b00, 0, 8'hFF, 8'hFF, 16'h0000, 0, "R1 R2 local narrow 0xFFFF");
    idle(2);
    // R4 boundary in split modes, R3 wide
    acc(2'b01, 1, 8'h00, 8'h00, 16'h0FFF, 0, "R4 R3 nb wide 0x0FFF");
    acc(2'b01, 1, 8'h00, 8'h00, 16'h1000, 1, "R4 R6 nb wide 0x1000");
    acc(2'b10, 1, 8'h00, 8'h00, 16'h0FFF, 0, "R4 bk wide 0x0FFF");
    acc(2'b10, 1, 8'h00, 8'h00, 16'hFFFF, 0, "R6 bk wide 0xFFFF");
    acc(2'b01, 0, 8'h0F, 8'hFF, 16'hFFFF, 0, "R4 R2 nb narrow 0x0FFF");
    // R5: nb narrow off-chip: low byte only
    acc(2'b01, 0, 8'h10, 8'h00, 16'h0000, 1, "R5 nb narrow 0x1000");
    acc(2'b01, 0, 8'hA5, 8'h3C, 16'h0123, 0, "R5 R2 nb narrow 0xA53C");
    idle(1);
    // R7: bk narrow off-chip: both enables, page on upper byte
    acc(2'b10, 0, 8'h10, 8'h00, 16'h0000, 0, "R7 bk narrow 0x1000");
    acc(2'b10, 0, 8'hC3, 8'h5A, 16'h0000, 1, "R7 R2 bk narrow 0xC35A");
    acc(2'b10, 0, 8'h0F, 8'hFF, 16'h8000, 0, "R4 bk narrow 0x0FFF");
    // R8: mode 11 always off-chip, even low addresses
    acc(2'b11, 0, 8'h00, 8'h00, 16'h0000, 0, "R8 remote narrow 0x0000");
    acc(2'b11, 1, 8'h00, 8'h00, 16'h0123, 1, "R8 R6 remote wide 0x0123");
    acc(2'b11, 0, 8'h12, 8'h34, 16'h0000, 0, "R8 remote narrow 0x1234");
    idle(1);
    // R11: back-to-back mode switch, same address
    acc(2'b00, 1, 8'h00, 8'h00, 16'h3456, 0, "R11 first mode 00");
    acc(2'b11, 1, 8'h00, 8'h00, 16'h3456, 0, "R11 second mode 11");
    acc(2'b01, 0, 8'h20, 8'h11, 16'h0000, 1, "R11 third mode 01");
    // R11: mode change without strobe after an access
    acc(2'b00, 1, 8'h00, 8'h00, 16'h5000, 0, "R11 mode 00 then change");
    mode_i = 2'b11;
    idle(3);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R10 leftover items actual=%0d expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule